// File: doc/BRIEF.md
# Inclusive Snoop Filter

This block sits between a shared coherence bus and a group of caches and decides, for every coherent request, which caches actually need to look up their tags. It keeps a small set-associative table of block addresses. Each entry holds a presence vector with one bit per cache, and a set bit means that cache may hold the block. A hit in the table means at least one cache holds the block. A miss means none does, so no cache needs to snoop.

All traffic arrives on one transaction channel. Reads and invalidating writes are the requests that need a snoop decision. Fill and evict notifications keep the presence vectors current. For each read or write, the filter returns a registered snoop-enable mask one cycle later. The requester's own bit is always removed from that mask. The filter only gates lookups at the receiving caches; it does not hold back the request on the bus.

When a new block has to be tracked and its set is full, the least recently used entry is dropped. Every cache still listed in that entry is then told to invalidate the block, which keeps the table inclusive of all cached copies.

Top module: `snoop_filter`

## Requirements
- R1: After reset the table tracks no block and `snp_valid` and `binv_valid` are low, so the first read of any address is a miss.
- R2: `txn_op` encodes 0 = read, 1 = invalidating write, 2 = fill notification, 3 = evict notification. `snp_valid` is high in exactly the cycle after each read or write is accepted (`txn_valid` high at a rising edge), and never follows a fill, an evict or an idle cycle.
- R3: A request whose block is not in the table gives `snp_hit` = 0 and an all-zero `snp_mask`.
- R4: A read sets the requester's presence bit, allocating an entry with only that bit if the block was absent. A later request from another cache gets a mask with exactly the recorded bits.
- R5: Bit `txn_src` of the requester is always clear in the `snp_mask` produced for its request.
- R6: An invalidating write snoops every other holder and then leaves only the writer's bit set in the entry.
- R7: A fill notification sets the source's bit (allocating on a miss). An evict notification clears the source's bit, and the entry is freed when its last bit clears. An evict for an untracked block or a clear bit changes nothing.
- R8: The set index is the low log2(SETS) bits of `txn_addr` and the tag is the remaining upper bits. A set holds WAYS blocks, and a free way is used before any valid entry is replaced.
- R9: In a full set the victim is the entry least recently touched by a read, write or fill. Evict notifications do not count as a use.
- R10: When a valid entry is replaced, `binv_valid` pulses in the same cycle as the request's snoop result, with `binv_addr` equal to the victim's full block address and `binv_mask` equal to its presence vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | A transaction is presented this cycle |
| txn_op | input | 2 | Transaction kind: 0 read, 1 invalidating write, 2 fill, 3 evict |
| txn_addr | input | ADDR_W | Block address |
| txn_src | input | $clog2(N_CACHES) | Index of the cache issuing the transaction |
| snp_valid | output | 1 | Snoop result for the request accepted in the previous cycle |
| snp_hit | output | 1 | That request found its block in the table |
| snp_mask | output | N_CACHES | One bit per cache that must perform a tag lookup |
| binv_valid | output | 1 | Back-invalidate of a replaced entry |
| binv_addr | output | ADDR_W | Block address to invalidate |
| binv_mask | output | N_CACHES | Caches that must drop that block |

## Verification
The hardest situation to reach is a replacement that depends on history. To get there, a set must be full, and the ordering of uses must be arranged so that the LRU choice differs from the order of allocation. An evict notification must also land on the oldest entry without refreshing it. The stimulus first fills one set through two different tags and touches the older one again. A third tag then forces a back-invalidate of the other entry. After that, an evict notification for a cache that holds no copy is sent to the least recent entry. Finally, another new tag shows whether that notification changed the victim order.

// File: rtl/sf_pkg.sv
package sf_pkg;
    typedef enum logic [1:0] {
        OP_READ      = 2'd0,
        OP_WRITE_INV = 2'd1,
        OP_FILL      = 2'd2,
        OP_EVICT     = 2'd3
    } sf_op_e;
endpackage

// File: rtl/sf_tag_match.sv
module sf_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            look_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld[w] && (tags[w] == look_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/sf_victim_sel.sv
module sf_victim_sel #(
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][WAY_W-1:0]  ages,
    output logic [WAY_W-1:0]            vic_way,
    output logic                        vic_occ
);
    always_comb begin
        vic_way = '0;
        vic_occ = 1'b1;
        for (int w = 0; w < WAYS; w++) begin
            if (ages[w] == WAY_W'(WAYS - 1)) vic_way = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) begin
                vic_way = WAY_W'(w);
                vic_occ = 1'b0;
            end
        end
    end
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter #(
    parameter int N_CACHES = 4,
    parameter int ADDR_W   = 12,
    parameter int SETS     = 16,
    parameter int WAYS     = 4,
    localparam int SRC_W   = (N_CACHES > 1) ? $clog2(N_CACHES) : 1,
    localparam int IDX_W   = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int TAG_W   = ADDR_W - IDX_W,
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                txn_valid,
    input  logic [1:0]          txn_op,
    input  logic [ADDR_W-1:0]   txn_addr,
    input  logic [SRC_W-1:0]    txn_src,
    output logic                snp_valid,
    output logic                snp_hit,
    output logic [N_CACHES-1:0] snp_mask,
    output logic                binv_valid,
    output logic [ADDR_W-1:0]   binv_addr,
    output logic [N_CACHES-1:0] binv_mask
);
    import sf_pkg::*;

    typedef struct packed {
        logic                vld;
        logic [TAG_W-1:0]    tag;
        logic [N_CACHES-1:0] pres;
        logic [WAY_W-1:0]    age;
    } entry_t;

    typedef struct packed {
        entry_t [SETS-1:0][WAYS-1:0] tab;
        logic                snp_valid;
        logic                snp_hit;
        logic [N_CACHES-1:0] snp_mask;
        logic                bi_valid;
        logic [ADDR_W-1:0]   bi_addr;
        logic [N_CACHES-1:0] bi_mask;
    } state_t;

    state_t st_d, st_q, st_rst;

    sf_op_e              op;
    logic [IDX_W-1:0]    idx;
    logic [TAG_W-1:0]    tag;
    logic [N_CACHES-1:0] src_bit;
    logic                is_snoop_op;

    logic [WAYS-1:0]            set_vld;
    logic [WAYS-1:0][TAG_W-1:0] set_tag;
    logic [WAYS-1:0][WAY_W-1:0] set_age;
    logic                       hit;
    logic [WAY_W-1:0]           hit_way;
    logic [WAY_W-1:0]           vic_way;
    logic                       vic_occ;

    assign op          = sf_op_e'(txn_op);
    assign idx         = txn_addr[IDX_W-1:0];
    assign tag         = txn_addr[ADDR_W-1:IDX_W];
    assign src_bit     = N_CACHES'(1) << txn_src;
    assign is_snoop_op = (op == OP_READ) || (op == OP_WRITE_INV);

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_vld[w] = st_q.tab[idx][w].vld;
            set_tag[w] = st_q.tab[idx][w].tag;
            set_age[w] = st_q.tab[idx][w].age;
        end
    end

    sf_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .vld      (set_vld),
        .tags     (set_tag),
        .look_tag (tag),
        .hit      (hit),
        .hit_way  (hit_way)
    );

    sf_victim_sel #(.WAYS(WAYS)) u_victim (
        .vld     (set_vld),
        .ages    (set_age),
        .vic_way (vic_way),
        .vic_occ (vic_occ)
    );

    // reset image: empty table, ages form a permutation per set
    always_comb begin
        st_rst = '0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                st_rst.tab[s][w].age = WAY_W'(w);
            end
        end
    end

    always_comb begin
        logic [WAY_W-1:0]    tw;
        logic                touch;
        logic [N_CACHES-1:0] left;

        st_d           = st_q;
        st_d.snp_valid = 1'b0;
        st_d.snp_hit   = 1'b0;
        st_d.snp_mask  = '0;
        st_d.bi_valid  = 1'b0;
        st_d.bi_addr   = '0;
        st_d.bi_mask   = '0;
        tw             = hit_way;
        touch          = 1'b0;
        left           = '0;

        if (txn_valid) begin
            if (is_snoop_op) begin
                st_d.snp_valid = 1'b1;
                st_d.snp_hit   = hit;
                st_d.snp_mask  = hit ? (st_q.tab[idx][hit_way].pres & ~src_bit) : '0;
            end

            if (op != OP_EVICT) begin
                touch = 1'b1;
                if (hit) begin
                    tw = hit_way;
                    if (op == OP_WRITE_INV)
                        st_d.tab[idx][tw].pres = src_bit;
                    else
                        st_d.tab[idx][tw].pres = st_q.tab[idx][tw].pres | src_bit;
                end else begin
                    tw = vic_way;
                    if (vic_occ) begin
                        st_d.bi_valid = 1'b1;
                        st_d.bi_addr  = {st_q.tab[idx][tw].tag, idx};
                        st_d.bi_mask  = st_q.tab[idx][tw].pres;
                    end
                    st_d.tab[idx][tw].vld  = 1'b1;
                    st_d.tab[idx][tw].tag  = tag;
                    st_d.tab[idx][tw].pres = src_bit;
                end
            end else if (hit) begin
                left = st_q.tab[idx][hit_way].pres & ~src_bit;
                st_d.tab[idx][hit_way].pres = left;
                if (left == '0) st_d.tab[idx][hit_way].vld = 1'b0;
            end

            if (touch) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == tw)
                        st_d.tab[idx][w].age = '0;
                    else if (st_q.tab[idx][w].age < st_q.tab[idx][tw].age)
                        st_d.tab[idx][w].age = st_q.tab[idx][w].age + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign snp_valid  = st_q.snp_valid;
    assign snp_hit    = st_q.snp_hit;
    assign snp_mask   = st_q.snp_mask;
    assign binv_valid = st_q.bi_valid;
    assign binv_addr  = st_q.bi_addr;
    assign binv_mask  = st_q.bi_mask;

    // R2
    snp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && is_snoop_op) |=> snp_valid);

    // R2
    snp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(txn_valid && is_snoop_op) |=> !snp_valid);

    // R3
    miss_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_hit) |-> (snp_mask == '0));

    // R5
    src_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && is_snoop_op) |=> ((snp_mask & (N_CACHES'(1) << $past(txn_src))) == '0));

    // R10
    binv_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        binv_valid |-> (binv_mask != '0) && !snp_hit);

    // R10
    binv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        binv_valid |-> ($past(txn_valid) && ($past(txn_op) != 2'd3)));

    // R7
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    pres_nonzero_chk: assert (!st_q.tab[s][w].vld || (st_q.tab[s][w].pres != '0));
                end
            end
        end
    end
endmodule

// File: tb/sim_snoop_filter.sv
module sim_snoop_filter;
    localparam int NC = 4;
    localparam int AW = 12;

    localparam logic [1:0] RD = 2'd0;
    localparam logic [1:0] WR = 2'd1;
    localparam logic [1:0] FL = 2'd2;
    localparam logic [1:0] EV = 2'd3;

    // address = {tag, 2-bit set index}
    localparam logic [AW-1:0] A_ADR = 12'h005; // tag 1, set 1
    localparam logic [AW-1:0] B_ADR = 12'h009; // tag 2, set 1
    localparam logic [AW-1:0] C_ADR = 12'h00A; // tag 2, set 2
    localparam logic [AW-1:0] D_ADR = 12'h00D; // tag 3, set 1
    localparam logic [AW-1:0] E_ADR = 12'h019; // tag 6, set 1
    localparam logic [AW-1:0] U_ADR = 12'h015; // tag 5, set 1

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          txn_valid = 1'b0;
    logic [1:0]    txn_op = 2'd0;
    logic [AW-1:0] txn_addr = '0;
    logic [1:0]    txn_src = '0;
    logic          snp_valid, snp_hit, binv_valid;
    logic [NC-1:0] snp_mask, binv_mask;
    logic [AW-1:0] binv_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        bit            sv;
        bit            hit;
        logic [NC-1:0] mask;
        bit            bv;
        logic [AW-1:0] ba;
        logic [NC-1:0] bm;
        string         req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    snoop_filter #(.N_CACHES(NC), .ADDR_W(AW), .SETS(4), .WAYS(2)) u0 (
        .clk(clk), .rst_n(rst_n),
        .txn_valid(txn_valid), .txn_op(txn_op), .txn_addr(txn_addr), .txn_src(txn_src),
        .snp_valid(snp_valid), .snp_hit(snp_hit), .snp_mask(snp_mask),
        .binv_valid(binv_valid), .binv_addr(binv_addr), .binv_mask(binv_mask)
    );

    task automatic step(input bit v, input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [1:0] s, input bit esv, input bit ehit,
                        input logic [NC-1:0] em, input bit ebv,
                        input logic [AW-1:0] eba, input logic [NC-1:0] ebm, input string r);
        exp_t e;
        @(negedge clk);
        txn_valid = v;
        txn_op    = op;
        txn_addr  = a;
        txn_src   = s;
        e.sv = esv; e.hit = ehit; e.mask = em; e.bv = ebv; e.ba = eba; e.bm = ebm; e.req = r;
        sb.push_back(e);
    endtask

    task automatic idle(input string r);
        step(1'b0, RD, '0, '0, 1'b0, 1'b0, '0, 1'b0, '0, '0, r);
    endtask

    // monitor: results registered at the rising edge, sampled 1 ns later
    initial begin
        exp_t e;
        bit bad;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb.size() > 0) begin
                e = sb.pop_front();
                bad = (snp_valid !== e.sv) || (binv_valid !== e.bv);
                if (e.sv && ((snp_hit !== e.hit) || (snp_mask !== e.mask))) bad = 1'b1;
                if (e.bv && ((binv_addr !== e.ba) || (binv_mask !== e.bm))) bad = 1'b1;
                checks++;
                if (bad) begin
                    fails++;
                    $display("FAIL %s: got sv=%0b hit=%0b mask=%b bv=%0b ba=%h bm=%b, exp sv=%0b hit=%0b mask=%b bv=%0b ba=%h bm=%b",
                             e.req, snp_valid, snp_hit, snp_mask, binv_valid, binv_addr, binv_mask,
                             e.sv, e.hit, e.mask, e.bv, e.ba, e.bm);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no completion, exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (snp_valid !== 1'b0 || binv_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: got sv=%0b bv=%0b, exp 0 0", snp_valid, binv_valid);
        end
        rst_n = 1'b1;

        idle("R1 idle after reset");
        step(1, RD, A_ADR, 2'd0, 1, 0, 4'b0000, 0, '0, '0, "R1 R3 first read misses");
        step(1, RD, A_ADR, 2'd1, 1, 1, 4'b0001, 0, '0, '0, "R4 second reader sees first");
        step(1, RD, A_ADR, 2'd0, 1, 1, 4'b0010, 0, '0, '0, "R5 own bit removed");
        step(1, FL, A_ADR, 2'd2, 0, 0, '0,      0, '0, '0, "R2 fill gives no snoop");
        step(1, RD, A_ADR, 2'd3, 1, 1, 4'b0111, 0, '0, '0, "R7 fill recorded");
        step(1, WR, A_ADR, 2'd2, 1, 1, 4'b1011, 0, '0, '0, "R6 write snoops others");
        step(1, RD, A_ADR, 2'd0, 1, 1, 4'b0100, 0, '0, '0, "R6 only writer remains");
        step(1, EV, A_ADR, 2'd2, 0, 0, '0,      0, '0, '0, "R2 evict gives no snoop");
        step(1, EV, A_ADR, 2'd0, 0, 0, '0,      0, '0, '0, "R7 last holder evicts");
        step(1, RD, A_ADR, 2'd1, 1, 0, 4'b0000, 0, '0, '0, "R7 freed entry misses");
        step(1, EV, U_ADR, 2'd1, 0, 0, '0,      0, '0, '0, "R7 untracked evict");
        step(1, RD, A_ADR, 2'd3, 1, 1, 4'b0010, 0, '0, '0, "R7 untracked evict no effect");
        step(1, RD, B_ADR, 2'd0, 1, 0, 4'b0000, 0, '0, '0, "R8 free way used");
        step(1, RD, C_ADR, 2'd1, 1, 0, 4'b0000, 0, '0, '0, "R8 same tag other set misses");
        step(1, RD, C_ADR, 2'd0, 1, 1, 4'b0010, 0, '0, '0, "R8 other set tracked");
        step(1, RD, A_ADR, 2'd2, 1, 1, 4'b1010, 0, '0, '0, "R9 touch older entry");
        step(1, WR, D_ADR, 2'd3, 1, 0, 4'b0000, 1, B_ADR, 4'b0001, "R10 full set back-invalidates LRU");
        step(1, RD, B_ADR, 2'd1, 1, 0, 4'b0000, 1, A_ADR, 4'b1110, "R9 R10 next LRU replaced");
        step(1, RD, D_ADR, 2'd0, 1, 1, 4'b1000, 0, '0, '0, "R9 recent entry kept");
        step(1, EV, B_ADR, 2'd3, 0, 0, '0,      0, '0, '0, "R9 evict on clear bit");
        step(1, RD, E_ADR, 2'd2, 1, 0, 4'b0000, 1, B_ADR, 4'b0010, "R9 evict did not refresh age");
        step(1, RD, D_ADR, 2'd1, 1, 1, 4'b1001, 0, '0, '0, "R9 survivor intact");
        idle("R2 no snoop when idle");
        idle("R2 trailing idle");

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule